// File: doc/BRIEF.md
# Serial Control Slave with Channel Diagnosis Readback

This block is the serial command port of a sixteen-channel low-side switch array. An external controller selects it by pulling an active-low chip select, then clocks a 16-bit command word into it most significant bit first. During the same transfer the block shifts a 16-bit status word back out. Incoming data are taken on the falling edge of the serial clock, and outgoing data move on the rising edge. The serial pins are oversampled by a fast system clock through a synchronizer, so all state lives in one clock domain.

The 16 channels are split into two groups of eight, and consecutive valid transfers alternate between them. Three readback forms are available. The full form returns the 2-bit diagnosis code of each channel in the current group. The compact form returns the eight parallel input levels together with one fault bit per channel of the current group. The echo form returns the word received in the previous valid transfer. A received word is acted on only when chip select rises after exactly sixteen clocks. Depending on its command field, it then sets the on/off request of one channel group, the readback form, or the rule (AND or OR) that the downstream combiner uses to merge these bits with the parallel inputs. The serial output is released while the block is not selected. This is modelled as an output-enable port.

Top module: `spi_diag_slave`

## Requirements
- R1: While rst_n is low, and right after it is released, chan_on_o is all zero, so and so_oe are 0, combine_and_o is 0 (OR rule), the readback form is full, and the next valid transfer reports channels 1-8.
- R2: so_oe is 1 while cs_n is low, after a few clk cycles of synchronizer latency, and 0 while cs_n is high.
- R3: si is captured on each sclk falling edge while cs_n is low. The first captured bit is bit 15 of the received word.
- R4: The status word is fixed when cs_n falls and its bit 15 is on so until the second sclk rising edge. Each later rising edge advances so to the next lower bit.
- R5: A word is applied only when cs_n rises after exactly 16 sclk falling edges. Any other count changes no output, no mode and no group selection.
- R6: Command field word[15:13] = 3'b110 sets chan_on_o[7:0] = word[7:0]. The value 3'b101 sets chan_on_o[15:8] = word[7:0].
- R7: Command field 3'b011 sets combine_and_o = word[0] (1 = AND rule, 0 = OR rule).
- R8: Command field 3'b100 sets the readback form from word[1:0]: 00 full, 01 compact, 10 echo, 11 full. The new form applies from the next transfer onward.
- R9: In full form, for group g (0 = channels 1-8, 1 = channels 9-16), status bits [2k+1:2k] equal diag_i[2(8g+k)+1 : 2(8g+k)] for k = 0..7.
- R10: In compact form, status bits [15:8] equal pin_i[7:0], and status bit k is the OR of the two diag_i bits of channel 8g+k.
- R11: In echo form, the status word equals the word received in the previous valid transfer, whatever its command field was.
- R12: The group selection starts at 0 and toggles after every valid transfer.
- R13: Command fields 3'b000, 3'b001, 3'b010 and 3'b111 change neither chan_on_o nor combine_and_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (0 = released) |
| diag_i | input | 32 | Two diagnosis bits per channel, channel c at bits [2c+1:2c] |
| pin_i | input | 8 | Parallel input levels |
| chan_on_o | output | 16 | On/off request per channel sent to the combiner |
| combine_and_o | output | 1 | Combine rule for the combiner: 1 AND, 0 OR |

## Verification
On every cycle, the assertions check three things. The channel and combine outputs move only at a chip-select rise. Such a rise after a wrong clock count leaves them untouched. so moves only at a counted rising edge or at the start of a transfer, and the output enable stays low during a settled idle period. The bench scenarios are what show the data content. They sweep all four readback settings over varied diagnosis and pin patterns, alternating groups, the echo of each previous word, every command code, and transfers of 15 and 17 clocks followed by a readback that proves the group selection did not advance.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;

    typedef enum logic [1:0] {
        RB_FULL    = 2'b00,
        RB_COMPACT = 2'b01,
        RB_ECHO    = 2'b10,
        RB_ALTFULL = 2'b11
    } rb_mode_e;

    localparam int CMD_W = 3;

    localparam logic [CMD_W-1:0] CMD_SET_LO   = 3'b110;
    localparam logic [CMD_W-1:0] CMD_SET_HI   = 3'b101;
    localparam logic [CMD_W-1:0] CMD_SET_MODE = 3'b100;
    localparam logic [CMD_W-1:0] CMD_SET_COMB = 3'b011;

endpackage

// File: rtl/spi_diag_sync.sv
module spi_diag_sync #(
    parameter int           N       = 1,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] ff_q [STAGES];
    logic [N-1:0] ff_d [STAGES];

    always_comb begin
        ff_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            ff_d[i] = ff_q[i-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q[s] <= RST_VAL;
                else        ff_q[s] <= ff_d[s];
            end
        end
    endgenerate

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/spi_diag_fmt.sv
module spi_diag_fmt #(
    parameter int NCH = 16,
    localparam int HALF = NCH / 2,
    localparam int W    = NCH
) (
    input  spi_diag_pkg::rb_mode_e mode,
    input  logic                   half,
    input  logic [2*NCH-1:0]       diag,
    input  logic [HALF-1:0]        pins,
    input  logic [W-1:0]           echo,
    output logic [W-1:0]           word
);
    logic [W-1:0]    full_w;
    logic [HALF-1:0] flag_w;

    generate
        for (genvar k = 0; k < HALF; k++) begin : g_ch
            logic [1:0] code;
            assign code = half ? diag[2*(HALF+k) +: 2] : diag[2*k +: 2];
            assign full_w[2*k +: 2] = code;
            assign flag_w[k]        = |code;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            spi_diag_pkg::RB_COMPACT: word = {pins, flag_w};
            spi_diag_pkg::RB_ECHO:    word = echo;
            default:                  word = full_w;
        endcase
    end
endmodule

// File: rtl/spi_diag_dec.sv
module spi_diag_dec #(
    parameter int NCH = 16,
    localparam int HALF = NCH / 2,
    localparam int W    = NCH
) (
    input  logic [W-1:0]           word,
    input  logic [NCH-1:0]         chan_q,
    input  logic                   comb_q,
    input  spi_diag_pkg::rb_mode_e mode_q,
    output logic [NCH-1:0]         chan_n,
    output logic                   comb_n,
    output spi_diag_pkg::rb_mode_e mode_n
);
    import spi_diag_pkg::*;

    logic [CMD_W-1:0] cmd;
    logic             unused_bits;

    assign cmd         = word[W-1 -: CMD_W];
    assign unused_bits = ^word[W-CMD_W-1:HALF];

    always_comb begin
        chan_n = chan_q;
        comb_n = comb_q;
        mode_n = mode_q;
        unique case (cmd)
            CMD_SET_LO:   chan_n[HALF-1:0]   = word[HALF-1:0];
            CMD_SET_HI:   chan_n[NCH-1:HALF] = word[HALF-1:0];
            CMD_SET_MODE: mode_n = rb_mode_e'(word[1:0]);
            CMD_SET_COMB: comb_n = word[0];
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_diag_slave.sv
module spi_diag_slave #(
    parameter int NCH         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             si,
    output logic             so,
    output logic             so_oe,
    input  logic [2*NCH-1:0] diag_i,
    input  logic [NCH/2-1:0] pin_i,
    output logic [NCH-1:0]   chan_on_o,
    output logic             combine_and_o
);
    import spi_diag_pkg::*;

    localparam int W      = NCH;
    localparam int CW     = $clog2(W + 2);
    localparam int CNTMAX = W + 1;

    typedef struct packed {
        logic           sclk_p;
        logic           cs_p;
        logic [CW-1:0]  cnt;
        logic [W-1:0]   rx;
        logic [W-1:0]   tx;
        logic [W-1:0]   echo;
        logic           half;
        rb_mode_e       mode;
        logic [NCH-1:0] chan;
        logic           comb_and;
    } st_t;

    st_t st_d, st_q;

    logic sclk_s, cs_s, si_s;
    logic cs_fall, cs_rise, sck_rise, sck_fall;
    logic [W-1:0]   fmt_word;
    logic [NCH-1:0] dec_chan;
    logic           dec_comb;
    rb_mode_e       dec_mode;

    spi_diag_sync #(
        .N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
    ) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d({sclk, cs_n, si}),
        .q({sclk_s, cs_s, si_s})
    );

    spi_diag_fmt #(.NCH(NCH)) fmt_i (
        .mode(st_q.mode), .half(st_q.half), .diag(diag_i),
        .pins(pin_i), .echo(st_q.echo), .word(fmt_word)
    );

    spi_diag_dec #(.NCH(NCH)) dec_i (
        .word(st_q.rx), .chan_q(st_q.chan), .comb_q(st_q.comb_and),
        .mode_q(st_q.mode), .chan_n(dec_chan), .comb_n(dec_comb),
        .mode_n(dec_mode)
    );

    assign cs_fall  = st_q.cs_p & ~cs_s;
    assign cs_rise  = ~st_q.cs_p & cs_s;
    assign sck_rise = ~cs_s & ~st_q.cs_p & sclk_s & ~st_q.sclk_p;
    assign sck_fall = ~cs_s & ~st_q.cs_p & ~sclk_s & st_q.sclk_p;

    always_comb begin
        st_d        = st_q;
        st_d.sclk_p = sclk_s;
        st_d.cs_p   = cs_s;
        if (cs_fall) begin
            st_d.cnt = '0;
            st_d.rx  = '0;
            st_d.tx  = fmt_word;
        end else begin
            if (sck_fall) begin
                st_d.rx = {st_q.rx[W-2:0], si_s};
                if (st_q.cnt != CW'(CNTMAX)) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sck_rise && st_q.cnt != '0) begin
                st_d.tx = {st_q.tx[W-2:0], 1'b0};
            end
        end
        if (cs_rise && st_q.cnt == CW'(W)) begin
            st_d.chan     = dec_chan;
            st_d.comb_and = dec_comb;
            st_d.mode     = dec_mode;
            st_d.echo     = st_q.rx;
            st_d.half     = ~st_q.half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cs_p     <= 1'b1;
            st_q.mode     <= RB_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign so            = st_q.tx[W-1];
    assign so_oe         = ~st_q.cs_p;
    assign chan_on_o     = st_q.chan;
    assign combine_and_o = st_q.comb_and;
endmodule

// File: rtl/spi_diag_chk.sv
module spi_diag_chk #(
    parameter int NCH = 16,
    localparam int W  = NCH,
    localparam int CW = $clog2(W + 2)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cs_n,
    input logic           so,
    input logic           so_oe,
    input logic [NCH-1:0] chan_on_o,
    input logic           combine_and_o,
    input logic           cs_rise,
    input logic           cs_fall,
    input logic           sck_rise,
    input logic [CW-1:0]  cnt
);
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

    a_r4_so_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_rise || cs_fall) |=> $stable(so));

    a_r5_bad_count_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && cnt != CW'(W)) |=> ($stable(chan_on_o) && $stable(combine_and_o)));

    a_r6_chan_only_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(chan_on_o));

    a_r7_comb_only_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(combine_and_o));
endmodule

bind spi_diag_slave spi_diag_chk #(.NCH(NCH)) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .so_oe(so_oe),
    .chan_on_o(chan_on_o), .combine_and_o(combine_and_o),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .sck_rise(sck_rise),
    .cnt(st_q.cnt)
);

// File: tb/spi_diag_slave_tb_top.sv
`timescale 1ns/1ps
module spi_diag_slave_tb_top;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        so, so_oe;
    logic [31:0] diag = '0;
    logic [7:0]  pins = '0;
    logic [15:0] chan_on;
    logic        comb_and;

    int total = 0;
    int bad   = 0;

    logic [15:0] m_chan = '0;
    logic        m_and  = 1'b0;
    logic [1:0]  m_mode = 2'b00;
    logic        m_half = 1'b0;
    logic [15:0] m_echo = '0;

    always #2 clk = ~clk;

    spi_diag_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .diag_i(diag), .pin_i(pins),
        .chan_on_o(chan_on), .combine_and_o(comb_and)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_rb();
        logic [15:0] r;
        logic [1:0]  c;
        for (int k = 0; k < 8; k++) begin
            c = diag[2*(8*m_half + k) +: 2];
            if (m_mode == 2'b01) r[k] = c[0] | c[1];
            else r[2*k +: 2] = c;
        end
        if (m_mode == 2'b01) r[15:8] = pins;
        if (m_mode == 2'b10) r = m_echo;
        return r;
    endfunction

    task automatic xfer(input logic [15:0] w, input int n);
        logic [15:0] rd;
        logic [15:0] ex;
        string       tag;
        ex  = exp_rb();
        tag = (m_mode == 2'b10) ? "R11 echo" : (m_mode == 2'b01) ? "R10 compact" : "R9 R12 full";
        rd  = '0;
        cs_n = 1'b0;
        tick(8);
        chk("R2 oe active", {31'd0, so_oe}, 32'd1);
        for (int i = 0; i < n; i++) begin
            si   = (i < 16) ? w[15-i] : 1'b0;
            sclk = 1'b1;
            tick(H);
            if (i < 16) rd[15-i] = so;
            sclk = 1'b0;
            tick(H);
        end
        tick(4);
        cs_n = 1'b1;
        tick(8);
        chk("R2 oe released", {31'd0, so_oe}, 32'd0);
        if (n >= 16) chk({tag, " R4 readback"}, {16'd0, rd}, {16'd0, ex});
        if (n == 16) begin
            case (w[15:13])
                3'b110: m_chan[7:0]  = w[7:0];
                3'b101: m_chan[15:8] = w[7:0];
                3'b100: m_mode       = w[1:0];
                3'b011: m_and        = w[0];
                default: ;
            endcase
            m_echo = w;
            m_half = ~m_half;
        end
        chk("R3 R5 R6 R13 chan_on", {16'd0, chan_on}, {16'd0, m_chan});
        chk("R5 R7 R13 combine", {31'd0, comb_and}, {31'd0, m_and});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(4);
        chk("R1 chan_on", {16'd0, chan_on}, 32'd0);
        chk("R1 so", {31'd0, so}, 32'd0);
        chk("R1 so_oe", {31'd0, so_oe}, 32'd0);
        chk("R1 combine", {31'd0, comb_and}, 32'd0);
        rst_n = 1'b1;
        tick(4);
        m_chan = '0; m_and = 1'b0; m_mode = 2'b00; m_half = 1'b0; m_echo = '0;
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(2);
        do_reset();

        // R8 R9 R10 R11 R12 R6: sweep every readback setting over diag and pin patterns
        for (int m = 0; m < 4; m++) begin
            xfer({3'b100, 11'd0, m[1:0]}, 16);
            for (int p = 0; p < 6; p++) begin
                diag = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF :
                       32'h1B3C_96E5 ^ (p * 32'h0107_0B0D);
                pins = 8'(p * 37 + m);
                xfer({3'b110, 5'd0, 8'(p * 29 + m)}, 16);
                xfer({3'b101, 5'd0, 8'(p * 53 + 7 * m)}, 16);
            end
        end

        // R7: combine rule
        xfer({3'b011, 12'd0, 1'b1}, 16);
        xfer({3'b011, 12'd0, 1'b0}, 16);
        xfer({3'b011, 12'd0, 1'b1}, 16);

        // R13: unused command codes leave outputs alone
        xfer({3'b110, 5'd0, 8'hA5}, 16);
        xfer({3'b000, 5'h1F, 8'hFF}, 16);
        xfer({3'b001, 5'h1F, 8'h00}, 16);
        xfer({3'b010, 5'h1F, 8'hFF}, 16);
        xfer({3'b111, 5'h1F, 8'h00}, 16);

        // R5: wrong clock counts are discarded, group does not advance
        diag = 32'hC3A5_5A3C;
        xfer({3'b110, 5'd0, 8'h3C}, 15);
        xfer({3'b101, 5'd0, 8'hC3}, 17);
        xfer({3'b100, 11'd0, 2'b10}, 15);
        xfer({3'b000, 5'd0, 8'h00}, 16);
        xfer({3'b100, 11'd0, 2'b10}, 16);
        xfer({3'b111, 13'h1234}, 16);
        xfer({3'b100, 11'd0, 2'b00}, 16);

        // R1 R12: reset returns to group 0 in full form
        xfer({3'b110, 5'd0, 8'hFF}, 16);
        do_reset();
        diag = 32'h8421_1248;
        xfer({3'b000, 13'd0}, 16);
        xfer({3'b000, 13'd0}, 16);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule